// File: doc/BRIEF.md
# Four-Node Wormhole Crossbar Switch

This block connects four nodes through a full crossbar, so any of the four inputs can reach any of the four outputs (sixteen paths in all). A node offers a 16-bit packet on its input with a valid/ready handshake. The packet holds a 4-bit start marker, a 2-bit source field, a 2-bit destination field and an 8-bit payload. The switch checks the marker and parks a good packet in a one-entry holding register at that input. It then forwards the 8-bit payload to the output named by the destination field.

When several held packets want the same output, a round-robin arbiter for that output picks one per cycle. A packet that loses stays in its holding register, and that input keeps ready low until the packet wins. Nothing is dropped and nothing is moved to other storage. An output that carries no word in a cycle does not drive its data bus, so the bus floats.

Top module: `wh_xbar_router`

## Requirements
- R1: After a synchronous active-high reset, every output has valid low, every input has ready high and error low, and every arbiter pointer is at port 0.
- R2: A packet with marker 4'b1010 in bits 15:12 and destination d in bits 9:8 has its bits 7:0 delivered on output d, from any input to any output. The source field in bits 11:10 plays no part in routing.
- R3: A packet accepted at clock edge E appears on its output with valid high for exactly one cycle, starting at edge E+1 at the earliest. Each output delivers at most one word per cycle.
- R4: In every cycle that an output's valid is low, that output's data bus is left undriven (high impedance).
- R5: Among the inputs holding packets for one output, the arbiter grants the first one found when scanning upward from its pointer, wrapping around. After each grant the pointer moves to the port after the winner. With all four inputs contending from reset, the order of service is 0, 1, 2, 3.
- R6: A packet whose bits 15:12 differ from 4'b1010 is discarded when it is accepted and is never delivered. Its input raises error for exactly the one cycle after that handshake.
- R7: An input's ready is low exactly while its holding register contains a packet. A held packet stays unchanged until it is granted, however long it is blocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Per-input packet valid |
| in_pkt | input | 64 | Input packets, input i in bits 16i+15:16i |
| in_ready | output | 4 | Per-input ready, high when the holding register is empty |
| in_err | output | 4 | Per-input one-cycle pulse for a packet with a bad marker |
| out_valid | output | 4 | Per-output one-cycle word strobe |
| out_data | output | 32 | Output words, output o in bits 8o+7:8o, high impedance when not valid |

## Verification
The bench loads all four inputs with packets for one output at once. An arbiter that starts at the wrong port, or moves its pointer to the wrong place, delivers the payloads out of order. It also sends long streams of mixed good and bad packets with random destinations into a reference model that tracks each holding register and pointer. A design that dropped a blocked packet, raised ready while a packet was still waiting, or forwarded a bad-marker packet would show a missing or extra word, or a wrong ready or error level. Idle outputs are checked in every cycle, which catches an output that keeps driving its last word after valid falls.

// File: rtl/wh_pkg.sv
package wh_pkg;
    localparam int NODES  = 4;
    localparam int ID_W   = (NODES > 1) ? $clog2(NODES) : 1;
    localparam int DATA_W = 8;
    localparam int MARK_W = 4;
    localparam int PKT_W  = MARK_W + 2 * ID_W + DATA_W;
    localparam logic [MARK_W-1:0] SOP_MARK = 4'b1010;

    typedef struct packed {
        logic [MARK_W-1:0] mark;
        logic [ID_W-1:0]   src;
        logic [ID_W-1:0]   dst;
        logic [DATA_W-1:0] data;
    } flit_t;

    function automatic logic mark_ok(flit_t f);
        return f.mark == SOP_MARK;
    endfunction
endpackage

// File: rtl/wh_in_port.sv
module wh_in_port
    import wh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  flit_t      in_pkt,
    output logic       in_ready,
    output logic       in_err,
    input  logic       release_i,
    output logic       hold_vld,
    output flit_t      hold_pkt
);
    logic  full_q;
    logic  err_q;
    flit_t pkt_q;
    logic  take;

    assign in_ready = !full_q;
    assign take     = in_valid && !full_q;
    assign hold_vld = full_q;
    assign hold_pkt = pkt_q;
    assign in_err   = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            err_q  <= 1'b0;
            pkt_q  <= '0;
        end else begin
            err_q <= 1'b0;
            if (release_i) begin
                full_q <= 1'b0;
            end
            if (take) begin
                if (mark_ok(in_pkt)) begin
                    full_q <= 1'b1;
                    pkt_q  <= in_pkt;
                end else begin
                    err_q  <= 1'b1;
                end
            end
        end
    end

    // R7: a waiting packet is neither lost nor altered
    a_r7_hold_kept: assert property (@(posedge clk) disable iff (rst)
        (full_q && !release_i) |=> (full_q && $stable(pkt_q)));

    // R6: a bad marker never fills the holding register and always flags
    a_r6_bad_dropped: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !mark_ok(in_pkt)) |=> (in_err && !hold_vld));

    // R6: no error without a preceding accepted handshake
    a_r6_err_cause: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> !in_err);

    // R7: release only happens to a full register
    a_r7_release_full: assert property (@(posedge clk) disable iff (rst)
        release_i |-> full_q);
endmodule

// File: rtl/wh_out_port.sv
module wh_out_port
    import wh_pkg::*;
#(
    parameter int N = NODES,
    parameter int W = DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        req,
    input  logic [N-1:0][W-1:0] data,
    output logic [N-1:0]        gnt,
    output logic                out_valid,
    output logic [W-1:0]        out_data
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] win;
    logic [PW-1:0] nxt;
    logic          hit;
    logic          v_q;
    logic [W-1:0]  d_q;

    always_comb begin
        gnt = '0;
        win = '0;
        hit = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(ptr_q) + k;
            if (idx >= N) idx = idx - N;
            if (!hit && req[idx]) begin
                hit      = 1'b1;
                gnt[idx] = 1'b1;
                win      = PW'(idx);
            end
        end
    end

    assign nxt = (int'(win) == N - 1) ? '0 : win + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            v_q   <= 1'b0;
            d_q   <= '0;
        end else begin
            v_q <= hit;
            if (hit) begin
                d_q   <= data[win];
                ptr_q <= nxt;
            end
        end
    end

    assign out_valid = v_q;
    assign out_data  = v_q ? d_q : {W{1'bz}};

    // R5: one winner at most, and only among requesters
    a_r5_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    a_r5_grant_has_req: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

    // R3: a word strobes exactly in the cycle after a grant
    a_r3_valid_after_grant: assert property (@(posedge clk) disable iff (rst)
        (|gnt) |=> out_valid);
    a_r3_no_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !(|req) |=> !out_valid);

    // R5: a pending request is never ignored while the output idles
    a_r5_no_starve: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|gnt));
endmodule

// File: rtl/wh_xbar_router.sv
module wh_xbar_router
    import wh_pkg::*;
#(
    parameter int N = NODES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        in_valid,
    input  logic [N*PKT_W-1:0]  in_pkt,
    output logic [N-1:0]        in_ready,
    output logic [N-1:0]        in_err,
    output logic [N-1:0]        out_valid,
    output logic [N*DATA_W-1:0] out_data
);
    logic  [N-1:0]              hold_vld;
    flit_t                      hold_pkt [N];
    logic  [N-1:0][DATA_W-1:0]  hold_data;
    logic  [N-1:0][N-1:0]       req_m;
    logic  [N-1:0][N-1:0]       gnt_m;
    logic  [N-1:0]              rel;

    for (genvar i = 0; i < N; i++) begin : g_in
        wh_in_port u_in (
            .clk      (clk),
            .rst      (rst),
            .in_valid (in_valid[i]),
            .in_pkt   (flit_t'(in_pkt[i*PKT_W +: PKT_W])),
            .in_ready (in_ready[i]),
            .in_err   (in_err[i]),
            .release_i(rel[i]),
            .hold_vld (hold_vld[i]),
            .hold_pkt (hold_pkt[i])
        );
        assign hold_data[i] = hold_pkt[i].data;
    end

    always_comb begin
        for (int o = 0; o < N; o++) begin
            for (int i = 0; i < N; i++) begin
                req_m[o][i] = hold_vld[i] && (int'(hold_pkt[i].dst) == o);
            end
        end
    end

    always_comb begin
        rel = '0;
        for (int o = 0; o < N; o++) begin
            rel = rel | gnt_m[o];
        end
    end

    for (genvar o = 0; o < N; o++) begin : g_out
        wh_out_port #(.N(N), .W(DATA_W)) u_out (
            .clk      (clk),
            .rst      (rst),
            .req      (req_m[o]),
            .data     (hold_data),
            .gnt      (gnt_m[o]),
            .out_valid(out_valid[o]),
            .out_data (out_data[o*DATA_W +: DATA_W])
        );
    end

    // R1: reset leaves every input ready and every output quiet
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (in_ready == '1 && out_valid == '0 && in_err == '0));

    // R2: a held packet is only released by the output it names
    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r2_right_output: assert property (@(posedge clk) disable iff (rst)
            rel[i] |-> gnt_m[hold_pkt[i].dst][i]);
    end
endmodule

// File: tb/wh_xbar_router_test.sv
module wh_xbar_router_test;
    localparam int N = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      in_valid = '0;
    logic [N*16-1:0]   in_pkt = '0;
    logic [N-1:0]      in_ready;
    logic [N-1:0]      in_err;
    logic [N-1:0]      out_valid;
    logic [N*8-1:0]    out_data;

    wh_xbar_router uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pkt(in_pkt),
        .in_ready(in_ready), .in_err(in_err),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    // reference model state
    bit        m_full [N];
    logic [15:0] m_pkt [N];
    int        m_ptr  [N];
    bit        e_valid[N];
    logic [7:0] e_data[N];
    bit        e_err  [N];
    bit        acc    [N];
    logic [15:0] txq [N][$];
    logic [7:0]  log0 [$];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
        end
    endtask

    // model advances at each rising edge from the inputs driven at the falling edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_full[i] = 0; m_ptr[i] = 0; e_valid[i] = 0; e_err[i] = 0; acc[i] = 0;
                e_data[i] = '0;
            end
        end else begin
            bit rdy [N];
            for (int i = 0; i < N; i++) rdy[i] = !m_full[i];
            for (int o = 0; o < N; o++) begin
                e_valid[o] = 0;
                for (int k = 0; k < N; k++) begin
                    int s;
                    s = (m_ptr[o] + k) % N;
                    if (!e_valid[o] && m_full[s] && int'(m_pkt[s][9:8]) == o) begin
                        e_valid[o] = 1;
                        e_data[o]  = m_pkt[s][7:0];
                        m_full[s]  = 0;
                        m_ptr[o]   = (s + 1) % N;
                        if (o == 0) log0.push_back(m_pkt[s][7:0]);
                    end
                end
            end
            for (int i = 0; i < N; i++) begin
                logic [15:0] p;
                p = in_pkt[i*16 +: 16];
                acc[i]   = in_valid[i] && rdy[i];
                e_err[i] = 0;
                if (acc[i]) begin
                    if (p[15:12] == 4'b1010) begin
                        m_full[i] = 1; m_pkt[i] = p;
                    end else begin
                        e_err[i] = 1;
                    end
                end
            end
        end
    end

    // compare, then drive the next inputs, all at the falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int o = 0; o < N; o++) begin
                logic [7:0] d;
                d = out_data[o*8 +: 8];
                chk(out_valid[o] == e_valid[o], "R3", $sformatf("out_valid[%0d]", o), out_valid[o], e_valid[o]);
                if (e_valid[o])
                    chk(d === e_data[o], "R2", $sformatf("out_data[%0d]", o), d, e_data[o]);
                else // a floating bus: z, or 0 where undriven nets resolve to zero
                    chk((d === 8'hzz) || (d === 8'h00), "R4", $sformatf("idle out_data[%0d]", o), d, 0);
                chk(in_err[o] == e_err[o], "R6", $sformatf("in_err[%0d]", o), in_err[o], e_err[o]);
                chk(in_ready[o] == !m_full[o], "R7", $sformatf("in_ready[%0d]", o), in_ready[o], !m_full[o]);
            end
        end
        for (int i = 0; i < N; i++) begin
            if (in_valid[i] && acc[i]) begin
                void'(txq[i].pop_front());
                acc[i] = 0;
            end
            if (!rst && txq[i].size() > 0) begin
                in_valid[i] = 1'b1;
                in_pkt[i*16 +: 16] = txq[i][0];
            end else begin
                in_valid[i] = 1'b0;
            end
        end
    end

    function automatic logic [15:0] mk(logic [3:0] mark, int src, int dst, logic [7:0] d);
        return {mark, 2'(src), 2'(dst), d};
    endfunction

    task automatic drain(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, seen before any traffic
        for (int i = 0; i < N; i++) begin
            chk(in_ready[i] == 1'b1, "R1", "ready after reset", in_ready[i], 1);
            chk(out_valid[i] == 1'b0, "R1", "valid after reset", out_valid[i], 0);
            chk(in_err[i] == 1'b0, "R1", "err after reset", in_err[i], 0);
        end
        @(posedge clk);
        // R5: all four inputs aim at output 0 together; from reset the order is 0,1,2,3
        for (int i = 0; i < N; i++) txq[i].push_back(mk(4'b1010, 3 - i, 0, 8'hA0 + 8'(i)));
        drain(12);
        chk(log0.size() == 4, "R5", "words on output 0", log0.size(), 4);
        for (int i = 0; i < 4 && i < log0.size(); i++)
            chk(log0[i] == 8'hA0 + 8'(i), "R5", "service order", log0[i], 8'hA0 + 8'(i));
        // R2: a permutation, every input to a different output
        for (int i = 0; i < N; i++) txq[i].push_back(mk(4'b1010, i, (i + 1) % N, 8'h50 + 8'(i)));
        drain(8);
        // R6: bad markers between good packets on one input
        txq[2].push_back(mk(4'b0101, 2, 1, 8'hEE));
        txq[2].push_back(mk(4'b1010, 2, 1, 8'h21));
        txq[2].push_back(mk(4'b1011, 2, 3, 8'hEF));
        txq[2].push_back(mk(4'b0000, 2, 3, 8'hED));
        drain(12);
        // R7: long contention on output 3 with back-to-back packets per input
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < N; i++) txq[i].push_back(mk(4'b1010, i, 3, 8'(16 * r + i)));
        drain(40);
        // mixed random traffic
        for (int n = 0; n < 600; n++) begin
            int i;
            logic [3:0] mk4;
            i = $urandom_range(0, N - 1);
            mk4 = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'b1010;
            txq[i].push_back(mk(mk4, $urandom_range(0, 3), $urandom_range(0, 3), 8'($urandom)));
            if ($urandom_range(0, 3) == 0) @(posedge clk);
        end
        drain(2000);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule